// File: doc/BRIEF.md
# CCD Readout Timing Sequencer

This block produces the digital clock and strobe waveforms that read a square-pixel CCD array through a single output amplifier. One clock cycle of the block is one 100 ns timing tick, so every edge it produces falls on a tick boundary. After a start request it walks the array row by row. Each row read inside the window begins with a fast flush of the serial register and a four-step vertical transfer. Each pixel then gets a correlated-double-sampling cycle: reset, reference integrate, charge dump, signal integrate, hold and convert. Each of these phases has its own programmable length in ticks.

A rectangular window (origin plus size) limits the slow, low-noise pixel cycle to a sub-area. Rows above the window get vertical transfers only. Columns left of the window are shifted out at the fast rate with no conversion. Reading stops after the last window pixel. All outputs are plain level signals with no back-pressure: the pixel-valid strobe marks the tick in which the converter is told to start, and the downstream capture logic must accept it in that tick. The array size is set by power-of-two parameters and defaults to 1024 by 1024.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset, and in the tick after the frame-done tick, the outputs show the idle pattern: parallel phases {p3,p2,p1} = 011, transfer gate 0, serial phases {s3,s2,s1} = 000, and summing gate, reset gate, clamp, integrate, hold, convert, pixel-valid and frame-done all 0.
- R2: A start request is taken only in the idle state. The window and tick-count inputs are captured at that clock edge. The next tick shows the idle pattern (an arming tick), and the first active pattern follows it. A start during a frame, including its frame-done tick, is ignored, and input changes after capture have no effect.
- R3: A vertical transfer is four steps of t_par ticks each, with ({p3,p2,p1}, transfer gate) = (110,0), (100,1), (101,1), (001,0). The serial phases are 000 during these steps. Outside vertical transfers the parallel phases hold 011.
- R4: Every row with index below the window row origin receives one vertical transfer and nothing else.
- R5: Every row inside the window starts with a flush of NCOLS fast shifts and is followed by its vertical transfer. Each fast shift is three steps of t_fast ticks: serial 001 with reset gate 1, then serial 010 with summing gate 1, then serial 100.
- R6: In a window row, each column with index below the window column origin gets one fast shift, with convert and pixel-valid held at 0.
- R7: Each window pixel runs, with serial phases in brackets: reset with clamp [001] for t_rst ticks, integrate [001] for t_int, summing gate [010] for t_xfr, integrate [100] for t_int, hold [100] for t_hold, then convert [100] for one tick.
- R8: Pixel-valid is 1 exactly in the one-tick convert step of each window pixel, once per pixel, and never elsewhere.
- R9: The window size fields hold size minus one. The last row and column are origin plus size-minus-one, clipped to the array edge. After the convert of the last column of the last window row the frame ends, and nothing is clocked for later rows or columns.
- R10: The frame ends with a single frame-done tick that carries the idle pattern.
- R11: A tick count of 0 is treated as 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one cycle per timing tick |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame start request |
| win_row0 | input | RW=log2(NROWS) | Window first row |
| win_rows_m1 | input | RW | Window height minus one |
| win_col0 | input | CW=log2(NCOLS) | Window first column |
| win_cols_m1 | input | CW | Window width minus one |
| t_par | input | TW | Ticks per vertical transfer step |
| t_fast | input | TW | Ticks per fast serial step |
| t_rst | input | TW | Reset/clamp ticks |
| t_int | input | TW | Ticks per integrate window |
| t_xfr | input | TW | Summing-gate dump ticks |
| t_hold | input | TW | Hold ticks |
| par_clk | output | 3 | Parallel phases {p3,p2,p1} |
| xfer_gate | output | 1 | Transfer gate into the serial register |
| ser_clk | output | 3 | Serial phases {s3,s2,s1} |
| sum_gate | output | 1 | Summing-well gate |
| reset_gate | output | 1 | Output node reset gate |
| clamp | output | 1 | Video clamp strobe |
| integ | output | 1 | Integrator enable |
| hold | output | 1 | Sample hold strobe |
| adc_start | output | 1 | Converter start strobe |
| pix_valid | output | 1 | Marks a converted window pixel |
| frame_done | output | 1 | One-tick end-of-frame pulse |

## Verification
A corrupted step register or timer shows up at the outputs in the very next tick as a pattern the four-step transfer or six-step pixel cycle never produces, or as a step whose length differs from its programmed count. A row or column counter that is off by one does not show inside a pixel. It shows at the next row or column boundary: a transfer where a flush should begin, a fast shift in place of a pixel, or a frame-done that comes a pixel or a row early or late. The bench therefore compares every output against a tick-exact model on every cycle, and also checks total frame lengths from a closed-form count.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_ARM, ST_DONE,
    ST_PT0, ST_PT1, ST_PT2, ST_PT3,
    ST_FL0, ST_FL1, ST_FL2,
    ST_SK0, ST_SK1, ST_SK2,
    ST_RST, ST_REF, ST_XFR, ST_SIG, ST_HLD, ST_CNV
  } step_t;

  typedef struct packed {
    logic [2:0] par;
    logic       tg;
    logic [2:0] ser;
    logic       sw;
    logic       rg;
    logic       clamp;
    logic       integ;
    logic       hold;
    logic       conv;
    logic       valid;
    logic       done;
  } wave_t;

  localparam wave_t WAVE_IDLE = '{par: 3'b011, tg: 1'b0, ser: 3'b000, sw: 1'b0,
                                  rg: 1'b0, clamp: 1'b0, integ: 1'b0, hold: 1'b0,
                                  conv: 1'b0, valid: 1'b0, done: 1'b0};

  // Output pattern of each step
  function automatic wave_t step_wave(step_t s);
    wave_t w;
    w = WAVE_IDLE;
    case (s)
      ST_DONE: w.done = 1'b1;
      ST_PT0:  w.par = 3'b110;
      ST_PT1:  begin w.par = 3'b100; w.tg = 1'b1; end
      ST_PT2:  begin w.par = 3'b101; w.tg = 1'b1; end
      ST_PT3:  w.par = 3'b001;
      ST_FL0, ST_SK0: begin w.ser = 3'b001; w.rg = 1'b1; end
      ST_FL1, ST_SK1: begin w.ser = 3'b010; w.sw = 1'b1; end
      ST_FL2, ST_SK2: w.ser = 3'b100;
      ST_RST:  begin w.ser = 3'b001; w.rg = 1'b1; w.clamp = 1'b1; end
      ST_REF:  begin w.ser = 3'b001; w.integ = 1'b1; end
      ST_XFR:  begin w.ser = 3'b010; w.sw = 1'b1; end
      ST_SIG:  begin w.ser = 3'b100; w.integ = 1'b1; end
      ST_HLD:  begin w.ser = 3'b100; w.hold = 1'b1; end
      ST_CNV:  begin w.ser = 3'b100; w.conv = 1'b1; w.valid = 1'b1; end
      default: ;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/ccdseq_timer.sv
module ccdseq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ccdseq_wave.sv
module ccdseq_wave
  import ccdseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  step_t nxt,
  output wave_t wv
);
  always_ff @(posedge clk) begin
    if (rst) wv <= WAVE_IDLE;
    else     wv <= step_wave(nxt);
  end
endmodule

// File: rtl/ccdseq_ctrl.sv
module ccdseq_ctrl
  import ccdseq_pkg::*;
#(
  parameter int NCOLS = 1024,
  parameter int NROWS = 1024,
  parameter int TW    = 16,
  localparam int CW   = $clog2(NCOLS),
  localparam int RW   = $clog2(NROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          tmr_zero,
  input  logic [RW-1:0] row0,
  input  logic [RW-1:0] row_last,
  input  logic [CW-1:0] col0,
  input  logic [CW-1:0] col_last,
  input  logic [TW-1:0] t_par,
  input  logic [TW-1:0] t_fast,
  input  logic [TW-1:0] t_rst,
  input  logic [TW-1:0] t_int,
  input  logic [TW-1:0] t_xfr,
  input  logic [TW-1:0] t_hold,
  output step_t         nxt,
  output logic          accept,
  output logic          load,
  output logic [TW-1:0] load_val
);
  localparam logic [CW-1:0] FL_LAST = CW'(NCOLS - 1);

  step_t         step;
  logic [RW-1:0] row, row_n, row_inc;
  logic [CW-1:0] col, col_n, col_inc;
  logic [CW-1:0] fl, fl_n;

  assign row_inc = row + 1'b1;
  assign col_inc = col + 1'b1;

  function automatic logic [TW-1:0] ticks_m1(logic [TW-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  always_comb begin
    nxt    = step;
    row_n  = row;
    col_n  = col;
    fl_n   = fl;
    accept = (step == ST_IDLE) && start;
    load   = accept;
    if (accept) begin
      nxt = ST_ARM;
    end else if (step != ST_IDLE && tmr_zero) begin
      load = 1'b1;
      case (step)
        ST_ARM: begin
          row_n = '0;
          fl_n  = '0;
          nxt   = (row0 == '0) ? ST_FL0 : ST_PT0;
        end
        ST_FL0: nxt = ST_FL1;
        ST_FL1: nxt = ST_FL2;
        ST_FL2: begin
          if (fl == FL_LAST) nxt = ST_PT0;
          else begin fl_n = fl + 1'b1; nxt = ST_FL0; end
        end
        ST_PT0: nxt = ST_PT1;
        ST_PT1: nxt = ST_PT2;
        ST_PT2: nxt = ST_PT3;
        ST_PT3: begin
          if (row < row0) begin
            row_n = row_inc;
            fl_n  = '0;
            nxt   = (row_inc >= row0) ? ST_FL0 : ST_PT0;
          end else begin
            col_n = '0;
            nxt   = (col0 == '0) ? ST_RST : ST_SK0;
          end
        end
        ST_SK0: nxt = ST_SK1;
        ST_SK1: nxt = ST_SK2;
        ST_SK2: begin
          col_n = col_inc;
          nxt   = (col_inc >= col0) ? ST_RST : ST_SK0;
        end
        ST_RST: nxt = ST_REF;
        ST_REF: nxt = ST_XFR;
        ST_XFR: nxt = ST_SIG;
        ST_SIG: nxt = ST_HLD;
        ST_HLD: nxt = ST_CNV;
        ST_CNV: begin
          if (col == col_last) begin
            if (row == row_last) nxt = ST_DONE;
            else begin row_n = row_inc; fl_n = '0; nxt = ST_FL0; end
          end else begin
            col_n = col_inc;
            nxt   = ST_RST;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (nxt)
      ST_PT0, ST_PT1, ST_PT2, ST_PT3:                 load_val = ticks_m1(t_par);
      ST_FL0, ST_FL1, ST_FL2, ST_SK0, ST_SK1, ST_SK2: load_val = ticks_m1(t_fast);
      ST_RST:                                         load_val = ticks_m1(t_rst);
      ST_REF, ST_SIG:                                 load_val = ticks_m1(t_int);
      ST_XFR:                                         load_val = ticks_m1(t_xfr);
      ST_HLD:                                         load_val = ticks_m1(t_hold);
      default:                                        load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= ST_IDLE;
      row  <= '0;
      col  <= '0;
      fl   <= '0;
    end else begin
      step <= nxt;
      row  <= row_n;
      col  <= col_n;
      fl   <= fl_n;
    end
  end
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccdseq_pkg::*;
#(
  parameter int NCOLS = 1024,
  parameter int NROWS = 1024,
  parameter int TW    = 16,
  localparam int CW   = $clog2(NCOLS),
  localparam int RW   = $clog2(NROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [RW-1:0] win_row0,
  input  logic [RW-1:0] win_rows_m1,
  input  logic [CW-1:0] win_col0,
  input  logic [CW-1:0] win_cols_m1,
  input  logic [TW-1:0] t_par,
  input  logic [TW-1:0] t_fast,
  input  logic [TW-1:0] t_rst,
  input  logic [TW-1:0] t_int,
  input  logic [TW-1:0] t_xfr,
  input  logic [TW-1:0] t_hold,
  output logic [2:0]    par_clk,
  output logic          xfer_gate,
  output logic [2:0]    ser_clk,
  output logic          sum_gate,
  output logic          reset_gate,
  output logic          clamp,
  output logic          integ,
  output logic          hold,
  output logic          adc_start,
  output logic          pix_valid,
  output logic          frame_done
);
  // Window end, clipped to the array edge (power-of-two array)
  logic [RW:0]   row_sum;
  logic [CW:0]   col_sum;
  logic [RW-1:0] row_end_in;
  logic [CW-1:0] col_end_in;

  assign row_sum    = {1'b0, win_row0} + {1'b0, win_rows_m1};
  assign col_sum    = {1'b0, win_col0} + {1'b0, win_cols_m1};
  assign row_end_in = row_sum[RW] ? {RW{1'b1}} : row_sum[RW-1:0];
  assign col_end_in = col_sum[CW] ? {CW{1'b1}} : col_sum[CW-1:0];

  // Settings captured at frame start
  logic [RW-1:0] c_row0, c_row_last;
  logic [CW-1:0] c_col0, c_col_last;
  logic [TW-1:0] c_par, c_fast, c_rst, c_int, c_xfr, c_hold;

  step_t         nxt;
  wave_t         wv;
  logic          accept, load, tmr_zero;
  logic [TW-1:0] load_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_row0 <= '0; c_row_last <= '0; c_col0 <= '0; c_col_last <= '0;
      c_par  <= '0; c_fast <= '0; c_rst <= '0; c_int <= '0; c_xfr <= '0; c_hold <= '0;
    end else if (accept) begin
      c_row0 <= win_row0; c_row_last <= row_end_in;
      c_col0 <= win_col0; c_col_last <= col_end_in;
      c_par  <= t_par;  c_fast <= t_fast; c_rst <= t_rst;
      c_int  <= t_int;  c_xfr  <= t_xfr;  c_hold <= t_hold;
    end
  end

  ccdseq_ctrl #(.NCOLS(NCOLS), .NROWS(NROWS), .TW(TW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .tmr_zero(tmr_zero),
    .row0(c_row0), .row_last(c_row_last), .col0(c_col0), .col_last(c_col_last),
    .t_par(c_par), .t_fast(c_fast), .t_rst(c_rst), .t_int(c_int),
    .t_xfr(c_xfr), .t_hold(c_hold),
    .nxt(nxt), .accept(accept), .load(load), .load_val(load_val)
  );

  ccdseq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .zero(tmr_zero)
  );

  ccdseq_wave u_wave (.clk(clk), .rst(rst), .nxt(nxt), .wv(wv));

  assign par_clk    = wv.par;
  assign xfer_gate  = wv.tg;
  assign ser_clk    = wv.ser;
  assign sum_gate   = wv.sw;
  assign reset_gate = wv.rg;
  assign clamp      = wv.clamp;
  assign integ      = wv.integ;
  assign hold       = wv.hold;
  assign adc_start  = wv.conv;
  assign pix_valid  = wv.valid;
  assign frame_done = wv.done;
endmodule

// File: rtl/ccd_readout_seq_chk.sv
module ccd_readout_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] par_clk,
  input logic       xfer_gate,
  input logic [2:0] ser_clk,
  input logic       sum_gate,
  input logic       reset_gate,
  input logic       clamp,
  input logic       integ,
  input logic       hold,
  input logic       adc_start,
  input logic       pix_valid,
  input logic       frame_done
);
  AST_DONE_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);                                             // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (par_clk == 3'b011 && ser_clk == 3'b000 && !xfer_gate)); // R10
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (par_clk == 3'b011 && ser_clk == 3'b000 && !pix_valid)); // R1
  AST_TG_WITH_P3: assert property (@(posedge clk) disable iff (rst)
    xfer_gate |-> par_clk[2]);                                               // R3
  AST_PAR_HELD: assert property (@(posedge clk) disable iff (rst)
    (ser_clk != 3'b000) |-> (par_clk == 3'b011));                            // R3
  AST_SER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ser_clk));                                                      // R5
  AST_SW_MID_PHASE: assert property (@(posedge clk) disable iff (rst)
    sum_gate |-> (ser_clk == 3'b010));                                       // R5
  AST_RG_FIRST_PHASE: assert property (@(posedge clk) disable iff (rst)
    reset_gate |-> (ser_clk == 3'b001));                                     // R7
  AST_CLAMP_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    clamp |-> reset_gate);                                                   // R7
  AST_HOLD_AFTER_INTEG: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $past(integ));                                           // R7
  AST_CONV_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> $past(hold));                                              // R7
  AST_VALID_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> !pix_valid);                                               // R8
  AST_VALID_WITH_CONV: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> adc_start);                                                // R8
endmodule

bind ccd_readout_seq ccd_readout_seq_chk u_chk (
  .clk(clk), .rst(rst), .par_clk(par_clk), .xfer_gate(xfer_gate),
  .ser_clk(ser_clk), .sum_gate(sum_gate), .reset_gate(reset_gate),
  .clamp(clamp), .integ(integ), .hold(hold), .adc_start(adc_start),
  .pix_valid(pix_valid), .frame_done(frame_done)
);

// File: tb/ccd_readout_seq_test.sv
module ccd_readout_seq_test;
  localparam int NC = 16;
  localparam int NR = 8;
  localparam int TW = 8;
  localparam int CW = 4;
  localparam int RW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, start;
  logic [RW-1:0] row0, rows_m1;
  logic [CW-1:0] col0, cols_m1;
  logic [TW-1:0] tp, tf, tr, ti, tx, th;
  logic [2:0]    par_clk, ser_clk;
  logic          xfer_gate, sum_gate, reset_gate, clamp, integ, hold;
  logic          adc_start, pix_valid, frame_done;

  int checks = 0;
  int bad = 0;

  ccd_readout_seq #(.NCOLS(NC), .NROWS(NR), .TW(TW)) uut (
    .clk(clk), .rst(rst), .start(start),
    .win_row0(row0), .win_rows_m1(rows_m1), .win_col0(col0), .win_cols_m1(cols_m1),
    .t_par(tp), .t_fast(tf), .t_rst(tr), .t_int(ti), .t_xfr(tx), .t_hold(th),
    .par_clk(par_clk), .xfer_gate(xfer_gate), .ser_clk(ser_clk), .sum_gate(sum_gate),
    .reset_gate(reset_gate), .clamp(clamp), .integ(integ), .hold(hold),
    .adc_start(adc_start), .pix_valid(pix_valid), .frame_done(frame_done)
  );

  // {par, tg, ser, sw, rg, clamp, integ, hold, conv, valid, done}
  logic [14:0] got;
  assign got = {par_clk, xfer_gate, ser_clk, sum_gate, reset_gate, clamp, integ,
                hold, adc_start, pix_valid, frame_done};

  localparam logic [14:0] P_IDLE = {3'b011, 1'b0, 3'b000, 8'h00};

  function automatic logic [14:0] pat(logic [2:0] p, logic t, logic [2:0] s, logic [7:0] f);
    return {p, t, s, f};
  endfunction

  function automatic int eff(logic [TW-1:0] d);
    return (d == '0) ? 1 : int'(d);
  endfunction

  // Reference model: queue of expected output words, one per tick
  logic [14:0] expq[$];
  string       tagq[$];
  logic [14:0] exp_w = P_IDLE;
  string       exp_t = "R1";
  logic        was_done = 1'b0;
  logic        armed = 1'b0;

  function automatic void push(logic [14:0] p, int n, string t);
    for (int k = 0; k < n; k++) begin
      expq.push_back(p);
      tagq.push_back(t);
    end
  endfunction

  function automatic void fast_shift(string t);
    push(pat(3'b011, 1'b0, 3'b001, 8'h40), eff(tf), t);
    push(pat(3'b011, 1'b0, 3'b010, 8'h80), eff(tf), t);
    push(pat(3'b011, 1'b0, 3'b100, 8'h00), eff(tf), t);
  endfunction

  function automatic void par_xfer(string t);
    push(pat(3'b110, 1'b0, 3'b000, 8'h00), eff(tp), t);
    push(pat(3'b100, 1'b1, 3'b000, 8'h00), eff(tp), t);
    push(pat(3'b101, 1'b1, 3'b000, 8'h00), eff(tp), t);
    push(pat(3'b001, 1'b0, 3'b000, 8'h00), eff(tp), t);
  endfunction

  function automatic void pixel();
    push(pat(3'b011, 1'b0, 3'b001, 8'h60), eff(tr), "R7");
    push(pat(3'b011, 1'b0, 3'b001, 8'h10), eff(ti), "R7");
    push(pat(3'b011, 1'b0, 3'b010, 8'h80), eff(tx), "R7");
    push(pat(3'b011, 1'b0, 3'b100, 8'h10), eff(ti), "R7");
    push(pat(3'b011, 1'b0, 3'b100, 8'h08), eff(th), "R7");
    push(pat(3'b011, 1'b0, 3'b100, 8'h06), 1, "R8");
  endfunction

  function automatic void build();
    int r0, rl, c0, cl;
    r0 = int'(row0); c0 = int'(col0);
    rl = r0 + int'(rows_m1); if (rl > NR - 1) rl = NR - 1;
    cl = c0 + int'(cols_m1); if (cl > NC - 1) cl = NC - 1;
    push(P_IDLE, 1, "R2");
    for (int r = 0; r <= rl; r++) begin
      if (r >= r0) for (int k = 0; k < NC; k++) fast_shift("R5");
      par_xfer((r < r0) ? "R4" : "R3");
      if (r >= r0)
        for (int c = 0; c <= cl; c++) begin
          if (c < c0) fast_shift("R6");
          else        pixel();
        end
    end
    push(pat(3'b011, 1'b0, 3'b000, 8'h01), 1, "R10");
  endfunction

  // Closed-form frame length in ticks, arming tick to frame-done tick inclusive
  function automatic int flen();
    int r0, rl, c0, cl, wr, wc;
    r0 = int'(row0); c0 = int'(col0);
    rl = r0 + int'(rows_m1); if (rl > NR - 1) rl = NR - 1;
    cl = c0 + int'(cols_m1); if (cl > NC - 1) cl = NC - 1;
    wr = rl - r0 + 1; wc = cl - c0 + 1;
    return 2 + r0 * 4 * eff(tp)
         + wr * (NC * 3 * eff(tf) + 4 * eff(tp) + c0 * 3 * eff(tf)
                 + wc * (eff(tr) + 2 * eff(ti) + eff(tx) + eff(th) + 1));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      expq.delete(); tagq.delete();
      exp_w = P_IDLE; exp_t = "R1"; was_done = 1'b0; armed = 1'b1;
    end else begin
      if (expq.size() == 0 && start && !was_done) build();
      if (expq.size() > 0) begin
        exp_w = expq.pop_front();
        exp_t = tagq.pop_front();
      end else begin
        exp_w = P_IDLE; exp_t = "R1";
      end
      was_done = exp_w[0];
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (got !== exp_w) begin
        bad++;
        $display("FAIL %s tick compare at %0t: actual=%b expected=%b", exp_t, $time, got, exp_w);
      end
    end
  end

  task automatic check(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic set_cfg(int r0, int rm, int c0, int cm, int p, int f, int s, int i, int x, int h);
    row0 = RW'(r0); rows_m1 = RW'(rm); col0 = CW'(c0); cols_m1 = CW'(cm);
    tp = TW'(p); tf = TW'(f); tr = TW'(s); ti = TW'(i); tx = TW'(x); th = TW'(h);
  endtask

  // Called at a negedge; optionally pokes start and settings mid-frame
  task automatic run_frame(string req, bit poke);
    int want, n;
    want = flen();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (poke) begin
      for (int k = 0; k < 20; k++) begin
        start = k[0];
        row0 = RW'(k); col0 = CW'(k); tp = TW'(k); ti = TW'(k + 3);
        @(negedge clk); n++;
      end
      start = 1'b0;
    end
    while (!frame_done) begin
      @(negedge clk); n++;
    end
    check(req, n, want, "frame length in ticks");
    @(negedge clk);
    check("R10", int'(got), int'(P_IDLE), "pattern after frame-done");
  endtask

  initial begin
    rst = 1'b1; start = 1'b0;
    set_cfg(0, 0, 0, 0, 1, 1, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", int'(got), int'(P_IDLE), "pattern after reset");
    repeat (2) @(negedge clk);

    set_cfg(0, 7, 0, 15, 1, 1, 1, 2, 1, 1);   run_frame("R5", 1'b0);
    set_cfg(3, 2, 5, 3, 2, 1, 3, 4, 2, 2);    run_frame("R4", 1'b0);
    set_cfg(3, 2, 5, 3, 2, 1, 3, 4, 2, 2);    run_frame("R6", 1'b0);
    set_cfg(6, 5, 12, 7, 1, 2, 1, 1, 1, 3);   run_frame("R9", 1'b0);
    set_cfg(2, 1, 3, 2, 0, 0, 0, 0, 0, 0);    run_frame("R11", 1'b0);
    set_cfg(7, 0, 15, 0, 3, 1, 2, 2, 1, 1);   run_frame("R8", 1'b0);
    set_cfg(3, 2, 5, 3, 2, 1, 3, 4, 2, 2);    run_frame("R2", 1'b1);

    // Start held high: second frame begins two ticks after frame-done (R2)
    begin
      int want, m;
      set_cfg(1, 1, 2, 1, 1, 1, 1, 1, 1, 1);
      want = flen();
      start = 1'b1;
      while (!frame_done) @(negedge clk);
      m = 0;
      @(negedge clk); m++;
      while (!frame_done) begin
        @(negedge clk); m++;
      end
      start = 1'b0;
      check("R2", m, want + 1, "ticks between back-to-back frame-done pulses");
      repeat (3) @(negedge clk);
      check("R1", int'(got), int'(P_IDLE), "idle after released start");
    end

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule